// File: doc/BRIEF.md
# Cycle-by-Cycle Current Limiter with Overcurrent Shutdown

This block sits between a fast peak-current comparator and a digital PWM generator. It ends the on-time of a switching cycle as soon as the sensed switch current crosses its threshold. Each switching cycle begins with a one-clock start strobe. A programmable leading-edge blanking window then hides the comparator for the first few clocks, because the turn-on spike would otherwise trip the limiter falsely. After the window closes, a high comparator sample raises a terminate request. The request stays high until the next cycle begins, and the PWM generator uses it to cut its active outputs short.

The block also keeps a count of consecutive switching cycles that contained a limit event. When that count reaches a programmed maximum, it latches an overcurrent shutdown flag. The flag stays set until software clears it. All of this runs in logic with no processor in the loop. A 4-bit threshold code for the external comparator DAC is passed straight through.

Top module: `cyc_ilimit`

## Requirements
- R1: While reset is asserted, term_req, ocp_shdn and ocp_cnt are all zero.
- R2: blank_sel, sampled in the cycle that cyc_start is high, selects a blanking window of 0, 4, 8 or 16 clocks for codes 0, 1, 2 and 3. The window counts the strobe clock as the first clock. A high cmp_hi inside the window has no effect on term_req or ocp_cnt.
- R3: With en high, a high cmp_hi sampled outside the window makes term_req high from the next rising clock edge.
- R4: Once high, term_req stays high until the edge that samples cyc_start. At that edge it goes low, unless a limit event is also sampled in that same strobe clock.
- R5: ocp_cnt rises by exactly one on the first limit event of a switching cycle. Later events in the same cycle do not change it.
- R6: At a cyc_start edge, if the cycle just ended had no limit event, ocp_cnt returns to zero.
- R7: On the edge where ocp_cnt reaches a non-zero ocp_max, ocp_shdn rises. While ocp_shdn is high, ocp_cnt is frozen.
- R8: ocp_shdn stays high until a clock with sw_clr high. That clock clears both ocp_shdn and ocp_cnt.
- R9: While en is low, term_req is low from the next edge and ocp_cnt never increases.
- R10: thr_code_out always equals thr_code_in, with no delay.
- R11: An ocp_max of zero never raises ocp_shdn. ocp_cnt saturates at all ones (15 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Limiter enable |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| cmp_hi | input | 1 | Synchronised peak-current comparator output |
| blank_sel | input | 2 | Leading-edge blanking length code |
| thr_code_in | input | 4 | Comparator threshold code from software |
| ocp_max | input | 4 | Consecutive limit-cycle count that triggers shutdown |
| sw_clr | input | 1 | Software clear of shutdown and count |
| thr_code_out | output | 4 | Threshold code to the comparator DAC |
| term_req | output | 1 | Terminate request to the PWM generator |
| ocp_shdn | output | 1 | Latched overcurrent shutdown |
| ocp_cnt | output | 4 | Consecutive limit-cycle count |

## Verification
A blanking counter loaded with the wrong length, or decremented at the wrong time, shows up at the ports as term_req rising one or more clocks early or late. The bench sees this on the first clock after the window should have closed. A wrong per-cycle event flag shows in ocp_cnt on the very next edge: the count steps twice in one cycle, or it fails to clear at the strobe after a clean cycle. A shutdown latch that is set or released wrongly shows as ocp_shdn changing on an edge other than the one where the count meets ocp_max or sw_clr is sampled.

// File: rtl/ilim_pkg.sv
package ilim_pkg;
  localparam int unsigned LEB_SEL_W = 2;

  // blanking length in clocks: 0, then UNIT doubling per code step
  function automatic int unsigned leb_cycles(input logic [LEB_SEL_W-1:0] code,
                                             input int unsigned unit);
    if (code == '0) return 0;
    return unit << (code - 1'b1);
  endfunction
endpackage

// File: rtl/ilim_leb.sv
module ilim_leb #(
  parameter int unsigned BLANK_UNIT = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cyc_start,
  input  logic [ilim_pkg::LEB_SEL_W-1:0] blank_sel,
  output logic                           blank_on
);
  localparam int unsigned BLANK_MAX = BLANK_UNIT << ((2 ** ilim_pkg::LEB_SEL_W) - 2);
  localparam int unsigned BW        = $clog2(BLANK_MAX + 1);

  logic [BW-1:0] remain_q;
  logic [BW-1:0] len_w;

  assign len_w    = BW'(ilim_pkg::leb_cycles(blank_sel, BLANK_UNIT));
  assign blank_on = cyc_start ? (len_w != '0) : (remain_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (cyc_start) begin
      remain_q <= (len_w != '0) ? len_w - 1'b1 : '0;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  // R2: the window never extends past its programmed length
  p_window_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (remain_q < BW'(BLANK_MAX)));
endmodule

// File: rtl/ilim_trip.sv
module ilim_trip (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_start,
  input  logic cmp_hi,
  input  logic blank_on,
  output logic term_q,
  output logic trip_evt,
  output logic first_evt,
  output logic cyc_clean
);
  assign trip_evt  = en & cmp_hi & ~blank_on;
  assign first_evt = trip_evt & (cyc_start | ~term_q);
  assign cyc_clean = cyc_start & ~term_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         term_q <= 1'b0;
    else if (!en)       term_q <= 1'b0;
    else if (cyc_start) term_q <= trip_evt;
    else                term_q <= term_q | trip_evt;
  end

  // R4: the request is held to the end of the switching cycle
  p_term_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (term_q && en && !cyc_start) |=> term_q);
  // R3: an unblanked event always raises the request
  p_trip_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |=> term_q);
endmodule

// File: rtl/ilim_ocp.sv
module ilim_ocp #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_clr,
  input  logic             first_evt,
  input  logic             cyc_clean,
  input  logic [CNT_W-1:0] ocp_max,
  output logic [CNT_W-1:0] cnt_q,
  output logic             shdn_q
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_TOP) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] base_w, nxt_w;
  logic             hit_max;

  assign base_w  = cyc_clean ? '0 : cnt_q;
  assign nxt_w   = first_evt ? sat_inc(base_w) : base_w;
  assign hit_max = first_evt && (ocp_max != '0) && (nxt_w == ocp_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      shdn_q <= 1'b0;
    end else if (sw_clr) begin
      cnt_q  <= '0;
      shdn_q <= 1'b0;
    end else if (!shdn_q) begin
      cnt_q <= nxt_w;
      if (hit_max) shdn_q <= 1'b1;
    end
  end

  // R5: the count moves by at most one step per clock
  p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));
  // R6: a clean cycle restarts the count
  p_clean_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_clean && !first_evt && !shdn_q) |=> (cnt_q == '0));
  // R8: shutdown only leaves through the software clear
  p_shdn_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_q && !sw_clr) |=> shdn_q);
endmodule

// File: rtl/cyc_ilimit.sv
module cyc_ilimit #(
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned THR_W      = 4,
  parameter int unsigned BLANK_UNIT = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic                           cyc_start,
  input  logic                           cmp_hi,
  input  logic [ilim_pkg::LEB_SEL_W-1:0] blank_sel,
  input  logic [THR_W-1:0]               thr_code_in,
  input  logic [CNT_W-1:0]               ocp_max,
  input  logic                           sw_clr,
  output logic [THR_W-1:0]               thr_code_out,
  output logic                           term_req,
  output logic                           ocp_shdn,
  output logic [CNT_W-1:0]               ocp_cnt
);
  logic blank_on;
  logic trip_evt;
  logic first_evt;
  logic cyc_clean;

  assign thr_code_out = thr_code_in;

  ilim_leb #(.BLANK_UNIT(BLANK_UNIT)) u_leb (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .blank_sel(blank_sel), .blank_on(blank_on)
  );

  ilim_trip u_trip (
    .clk(clk), .rst_n(rst_n), .en(en), .cyc_start(cyc_start),
    .cmp_hi(cmp_hi), .blank_on(blank_on), .term_q(term_req),
    .trip_evt(trip_evt), .first_evt(first_evt), .cyc_clean(cyc_clean)
  );

  ilim_ocp #(.CNT_W(CNT_W)) u_ocp (
    .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .first_evt(first_evt),
    .cyc_clean(cyc_clean), .ocp_max(ocp_max), .cnt_q(ocp_cnt), .shdn_q(ocp_shdn)
  );

  // R2: the strobe clock is blanked for any non-zero code
  p_blank_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && blank_sel != '0) |=> !term_req);
  // R9: disabling drops the request
  p_dis_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !term_req);
  // R7: shutdown rises exactly at the programmed count
  p_shdn_at_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocp_shdn) |-> (ocp_cnt == $past(ocp_max)));
  // R10: threshold code is a straight pass-through
  always_comb begin
    p_thr_pass_r10: assert (thr_code_out == thr_code_in);
  end
endmodule

// File: tb/cyc_ilimit_tb_top.sv
module cyc_ilimit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       cyc_start = 1'b0;
  logic       cmp_hi = 1'b0;
  logic [1:0] blank_sel = 2'd0;
  logic [3:0] thr_code_in = 4'd0;
  logic [3:0] ocp_max = 4'd7;
  logic       sw_clr = 1'b0;
  logic [3:0] thr_code_out;
  logic       term_req;
  logic       ocp_shdn;
  logic [3:0] ocp_cnt;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic       term;
    logic       shdn;
    logic [3:0] cnt;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  // bench-side state of the reference behaviour
  logic m_term = 1'b0;
  logic m_shdn = 1'b0;
  int   m_cnt  = 0;
  int   m_idx  = 255;

  always #10 clk = ~clk;

  cyc_ilimit dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cyc_start(cyc_start), .cmp_hi(cmp_hi),
    .blank_sel(blank_sel), .thr_code_in(thr_code_in), .ocp_max(ocp_max),
    .sw_clr(sw_clr), .thr_code_out(thr_code_out), .term_req(term_req),
    .ocp_shdn(ocp_shdn), .ocp_cnt(ocp_cnt)
  );

  // monitor: pop one expectation per edge, well after the edge
  always @(posedge clk) begin
    #5;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (term_req !== e.term || ocp_shdn !== e.shdn || ocp_cnt !== e.cnt) begin
        n_bad++;
        $display("FAIL %s: term/shdn/cnt got %0b/%0b/%0d expected %0b/%0b/%0d",
                 e.tag, term_req, ocp_shdn, ocp_cnt, e.term, e.shdn, e.cnt);
      end
    end
  end

  task automatic blank_len(input logic [1:0] code, output int len);
    case (code)
      2'd0: len = 0;
      2'd1: len = 4;
      2'd2: len = 8;
      default: len = 16;
    endcase
  endtask

  // driver: apply one clock of stimulus and queue what must follow it
  task automatic step(input logic st, input logic cmp, input logic clr, input string tag);
    int   len;
    logic hit, first, clean, nterm, nshdn;
    int   c;
    exp_t e;
    @(negedge clk);
    cyc_start = st; cmp_hi = cmp; sw_clr = clr;
    m_idx = st ? 0 : ((m_idx < 255) ? m_idx + 1 : 255);
    blank_len(blank_sel, len);
    hit   = en && cmp && (m_idx >= len);
    first = hit && (st || !m_term);
    clean = st && !m_term;
    nterm = !en ? 1'b0 : (st ? hit : (m_term || hit));
    if (clr) begin
      c = 0; nshdn = 1'b0;
    end else if (m_shdn) begin
      c = m_cnt; nshdn = 1'b1;
    end else begin
      c = clean ? 0 : m_cnt;
      if (first) c = (c == 15) ? 15 : c + 1;
      nshdn = first && (ocp_max != 0) && (c == int'(ocp_max));
    end
    m_term = nterm; m_cnt = c; m_shdn = nshdn;
    e.term = nterm; e.shdn = nshdn; e.cnt = 4'(c); e.tag = tag;
    sb_q.push_back(e);
  endtask

  // one switching cycle of n clocks, comparator high for lo<=idx<hi or idx==p2
  task automatic run_cycle(input int n, input int lo, input int hi, input int p2,
                           input string tag);
    for (int i = 0; i < n; i++)
      step(i == 0, ((i >= lo) && (i < hi)) || (i == p2), 1'b0, tag);
  endtask

  task automatic set_cfg(input logic e_v, input logic [1:0] s_v, input logic [3:0] m_v);
    @(posedge clk); #1;
    en = e_v; blank_sel = s_v; ocp_max = m_v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;  // R1 reset state
    if (term_req !== 1'b0 || ocp_shdn !== 1'b0 || ocp_cnt !== 4'd0) begin
      n_bad++;
      $display("FAIL R1: term/shdn/cnt got %0b/%0b/%0d expected 0/0/0",
               term_req, ocp_shdn, ocp_cnt);
    end
    thr_code_in = 4'hA; #1;
    n_chk++;  // R10 pass-through
    if (thr_code_out !== 4'hA) begin
      n_bad++;
      $display("FAIL R10: thr got %0h expected a", thr_code_out);
    end
    thr_code_in = 4'h3; #1;
    n_chk++;
    if (thr_code_out !== 4'h3) begin
      n_bad++;
      $display("FAIL R10: thr got %0h expected 3", thr_code_out);
    end
    @(negedge clk); rst_n = 1'b1;
    set_cfg(1'b1, 2'd0, 4'd7);
    run_cycle(6, 0, 99, -1, "R3");
    set_cfg(1'b1, 2'd1, 4'd7);
    run_cycle(8, 1, 99, -1, "R2");
    set_cfg(1'b1, 2'd2, 4'd7);
    run_cycle(12, 0, 99, -1, "R2");
    set_cfg(1'b1, 2'd3, 4'd7);
    run_cycle(20, 0, 99, -1, "R2");
    run_cycle(20, 0, 16, -1, "R2");
    set_cfg(1'b1, 2'd1, 4'd7);
    run_cycle(10, 99, 99, -1, "R6");
    run_cycle(12, 5, 6, 9, "R4");
    run_cycle(12, 4, 12, -1, "R5");
    set_cfg(1'b1, 2'd0, 4'd7);
    run_cycle(4, 0, 4, -1, "R4");
    set_cfg(1'b1, 2'd0, 4'd4);
    run_cycle(6, 2, 6, -1, "R7");
    run_cycle(6, 2, 6, -1, "R8");
    run_cycle(6, 99, 99, -1, "R8");
    step(1'b0, 1'b0, 1'b1, "R8");
    run_cycle(6, 99, 99, -1, "R8");
    run_cycle(6, 2, 6, -1, "R8");
    set_cfg(1'b0, 2'd0, 4'd4);
    run_cycle(8, 0, 8, -1, "R9");
    run_cycle(8, 0, 8, -1, "R9");
    set_cfg(1'b1, 2'd0, 4'd0);
    for (int k = 0; k < 17; k++) run_cycle(5, 1, 5, -1, "R11");
    run_cycle(5, 99, 99, -1, "R6");
    step(1'b0, 1'b0, 1'b0, "R6");
    repeat (3) @(posedge clk);
    #6;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule